// File: doc/BRIEF.md
# Tiered Configuration Lock for a PWM Timer

This unit stores the safety-relevant configuration of a PWM timer and decides, on every register write, whether that write may land. Software programs a two-bit protection level once after reset. Each level shields a larger group of fields than the one below it. The first group covers dead-time, idle output levels, break settings and automatic output enable. The second adds the output polarities and the off-state selects. The third adds each channel's compare mode and compare preload. A write that the current level forbids is dropped without any signal, and the field keeps its old value.

The protection level register can be written only once. The first write to it uses up that one chance, even when it writes level zero. After that the level is fixed until the next reset. Polarity protection and compare-mode protection also depend on each channel's direction. A channel that is not currently set as an output stays writable at every level. The stored fields leave the block as ports, so a timer datapath can use them directly.

Writes use a single-cycle strobe with a 4-bit address and a 16-bit data word. The register map is: 0x0 lock level, 0x1 dead-time code, 0x2 break settings, 0x3 idle levels, 0x4 secondary dead-time, 0x5 polarities, 0x6 off-state selects, and 0x8 plus the channel number for that channel's compare controls.

Top module: `cfglock_top`

## Requirements
- R1: After reset, the lock level is 00 and every stored field reads zero. The one-time lock write is available again.
- R2: The first write to address 0x0 after reset loads wr_data[1:0] into the lock level and uses up the one-time write. A first write of 00 also uses it up.
- R3: Every later write to address 0x0 is ignored, and the lock level holds until reset.
- R4: At level 00, every field accepts writes. Each write updates its field on the next clock edge.
- R5: At any nonzero level, writes to these addresses are ignored:
  - 0x1: dead-time code, wr_data[7:0]
  - 0x2: break settings, wr_data[3:0], and auto-enable, wr_data[4]
  - 0x3: main idle levels, wr_data[1:0], and complementary idle levels, wr_data[3:2]
- R6: At any nonzero level, writes to 0x4 are ignored. This address holds the secondary dead-time code, wr_data[7:0], and the dead-time preload enable, wr_data[8].
- R7: At level 10 or 11, writes to 0x6 are ignored. This address holds the run off-state select, wr_data[0], and the idle off-state select, wr_data[1].
- R8: At level 10 or 11, a write to 0x5 leaves channel c's polarity bits unchanged when chan_out[c] is 1. Those bits are main polarity bit c and complementary polarity bit 2+c. The bits of a channel whose chan_out is 0 still update.
- R9: At level 11, a write to 0x8+c is ignored when chan_out[c] is 1, and is accepted when chan_out[c] is 0. The register holds the compare mode, wr_data[2:0], and the compare preload, wr_data[3].
- R10: A lower level leaves the higher groups writable. Level 01 still accepts polarity, off-state and compare writes. Level 10 still accepts compare writes.
- R11: A reset restores the R1 state from any level and allows a new one-time lock write.
- R12: Writes to addresses outside the map (0x7, 0xA to 0xF) change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| chan_out | input | NCH | Per channel: 1 when the channel is configured as an output |
| lock_level | output | 2 | Current protection level |
| dt_code | output | DT_W | Dead-time code |
| brk_cfg | output | BRK_W | Break settings |
| auto_oe | output | 1 | Automatic output enable |
| idle_main | output | NCH | Idle level of each main output |
| idle_comp | output | NCH | Idle level of each complementary output |
| dt2_code | output | DT_W | Secondary dead-time code |
| dt_preload | output | 1 | Dead-time preload enable |
| pol_main | output | NCH | Main output polarity per channel |
| pol_comp | output | NCH | Complementary output polarity per channel |
| off_run | output | 1 | Off-state select in run mode |
| off_idle | output | 1 | Off-state select in idle mode |
| oc_mode | output | 3*NCH | Compare mode, 3 bits per channel |
| oc_preload | output | NCH | Compare preload enable per channel |

## Verification
The hardest case to reach is a mixed-direction write at a high level. One polarity or compare write must be refused for an output channel and accepted for an input channel in the same cycle. This only matters after software has committed the level with its single write, and that write cannot be redone without a reset. The stimulus therefore resets several times and commits a different level each time, loading known nonzero field values first. It then issues writes under chosen chan_out patterns, and randomized rounds add every level and direction mix. A behavioural model compares every output on every cycle.

// File: rtl/cfglock_pkg.sv
package cfglock_pkg;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    LVL_OPEN  = 2'd0,
    LVL_ONE   = 2'd1,
    LVL_TWO   = 2'd2,
    LVL_THREE = 2'd3
  } lvl_e;

  localparam logic [ADDR_W-1:0] A_LOCK  = 4'h0;
  localparam logic [ADDR_W-1:0] A_DT    = 4'h1;
  localparam logic [ADDR_W-1:0] A_BRK   = 4'h2;
  localparam logic [ADDR_W-1:0] A_IDLE  = 4'h3;
  localparam logic [ADDR_W-1:0] A_DT2   = 4'h4;
  localparam logic [ADDR_W-1:0] A_POL   = 4'h5;
  localparam logic [ADDR_W-1:0] A_OFF   = 4'h6;
  localparam logic [ADDR_W-1:0] A_MODE0 = 4'h8;

  // write enables for the fields that are not per channel
  typedef struct packed {
    logic lock;
    logic dt;
    logic brk;
    logic idle;
    logic dt2;
    logic off;
  } we_s;

endpackage

// File: rtl/cfglock_rstsync.sv
module cfglock_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic core_rst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign core_rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/cfglock_level.sv
module cfglock_level
  import cfglock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_lock,
  input  logic [1:0] lvl_in,
  output lvl_e       lvl
);
  lvl_e lvl_q, lvl_d;
  logic used_q, used_d;
  logic load;

  // next state: only the first lock write after reset is taken
  always_comb begin
    load   = we_lock && !used_q;
    lvl_d  = lvl_q;
    used_d = used_q;
    if (load) begin
      lvl_d  = lvl_e'(lvl_in);
      used_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= LVL_OPEN;
      used_q <= 1'b0;
    end else if (load) begin
      lvl_q  <= lvl_d;
      used_q <= used_d;
    end
  end

  assign lvl = lvl_q;
endmodule

// File: rtl/cfglock_gate.sv
module cfglock_gate
  import cfglock_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  lvl_e              lvl,
  input  logic [NCH-1:0]    chan_out,
  output we_s               we,
  output logic [NCH-1:0]    we_pol,
  output logic [NCH-1:0]    we_mode
);
  logic tier1, tier2, tier3;
  logic pol_hit;

  always_comb begin
    tier1   = (lvl != LVL_OPEN);
    tier2   = (lvl == LVL_TWO) || (lvl == LVL_THREE);
    tier3   = (lvl == LVL_THREE);
    pol_hit = wr_en && (wr_addr == A_POL);
    we.lock = wr_en && (wr_addr == A_LOCK);
    we.dt   = wr_en && (wr_addr == A_DT)   && !tier1;
    we.brk  = wr_en && (wr_addr == A_BRK)  && !tier1;
    we.idle = wr_en && (wr_addr == A_IDLE) && !tier1;
    we.dt2  = wr_en && (wr_addr == A_DT2)  && !tier1;
    we.off  = wr_en && (wr_addr == A_OFF)  && !tier2;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] MADDR = ADDR_W'(int'(A_MODE0) + c);
    // direction-dependent shielding: only output channels are held
    assign we_pol[c]  = pol_hit && !(tier2 && chan_out[c]);
    assign we_mode[c] = wr_en && (wr_addr == MADDR) && !(tier3 && chan_out[c]);
  end
endmodule

// File: rtl/cfglock_fields.sv
module cfglock_fields
  import cfglock_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int DT_W  = 8,
  parameter int BRK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  we_s               we,
  input  logic [NCH-1:0]    we_pol,
  input  logic [NCH-1:0]    we_mode,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DT_W-1:0]   dt_code,
  output logic [BRK_W-1:0]  brk_cfg,
  output logic              auto_oe,
  output logic [NCH-1:0]    idle_main,
  output logic [NCH-1:0]    idle_comp,
  output logic [DT_W-1:0]   dt2_code,
  output logic              dt_preload,
  output logic [NCH-1:0]    pol_main,
  output logic [NCH-1:0]    pol_comp,
  output logic              off_run,
  output logic              off_idle,
  output logic [3*NCH-1:0]  oc_mode,
  output logic [NCH-1:0]    oc_preload
);
  logic unused_wdata;
  assign unused_wdata = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dt_code <= '0;
    else if (we.dt) dt_code <= wr_data[DT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_cfg <= '0;
      auto_oe <= 1'b0;
    end else if (we.brk) begin
      brk_cfg <= wr_data[BRK_W-1:0];
      auto_oe <= wr_data[BRK_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_main <= '0;
      idle_comp <= '0;
    end else if (we.idle) begin
      idle_main <= wr_data[NCH-1:0];
      idle_comp <= wr_data[2*NCH-1:NCH];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dt2_code   <= '0;
      dt_preload <= 1'b0;
    end else if (we.dt2) begin
      dt2_code   <= wr_data[DT_W-1:0];
      dt_preload <= wr_data[DT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_run  <= 1'b0;
      off_idle <= 1'b0;
    end else if (we.off) begin
      off_run  <= wr_data[0];
      off_idle <= wr_data[1];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pol_main[c] <= 1'b0;
        pol_comp[c] <= 1'b0;
      end else if (we_pol[c]) begin
        pol_main[c] <= wr_data[c];
        pol_comp[c] <= wr_data[NCH+c];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        oc_mode[3*c +: 3] <= '0;
        oc_preload[c]     <= 1'b0;
      end else if (we_mode[c]) begin
        oc_mode[3*c +: 3] <= wr_data[2:0];
        oc_preload[c]     <= wr_data[3];
      end
    end
  end
endmodule

// File: rtl/cfglock_top.sv
module cfglock_top
  import cfglock_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int DT_W  = 8,
  parameter int BRK_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [3:0]         wr_addr,
  input  logic [15:0]        wr_data,
  input  logic [NCH-1:0]     chan_out,
  output logic [1:0]         lock_level,
  output logic [DT_W-1:0]    dt_code,
  output logic [BRK_W-1:0]   brk_cfg,
  output logic               auto_oe,
  output logic [NCH-1:0]     idle_main,
  output logic [NCH-1:0]     idle_comp,
  output logic [DT_W-1:0]    dt2_code,
  output logic               dt_preload,
  output logic [NCH-1:0]     pol_main,
  output logic [NCH-1:0]     pol_comp,
  output logic               off_run,
  output logic               off_idle,
  output logic [3*NCH-1:0]   oc_mode,
  output logic [NCH-1:0]     oc_preload
);
  logic           core_rst_n;
  lvl_e           lvl;
  we_s            we;
  logic [NCH-1:0] we_pol;
  logic [NCH-1:0] we_mode;

  cfglock_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_rst_n (core_rst_n)
  );

  cfglock_level u_level (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .we_lock (we.lock),
    .lvl_in  (wr_data[1:0]),
    .lvl     (lvl)
  );

  cfglock_gate #(.NCH(NCH)) u_gate (
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .lvl      (lvl),
    .chan_out (chan_out),
    .we       (we),
    .we_pol   (we_pol),
    .we_mode  (we_mode)
  );

  cfglock_fields #(.NCH(NCH), .DT_W(DT_W), .BRK_W(BRK_W)) u_fields (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .we         (we),
    .we_pol     (we_pol),
    .we_mode    (we_mode),
    .wr_data    (wr_data),
    .dt_code    (dt_code),
    .brk_cfg    (brk_cfg),
    .auto_oe    (auto_oe),
    .idle_main  (idle_main),
    .idle_comp  (idle_comp),
    .dt2_code   (dt2_code),
    .dt_preload (dt_preload),
    .pol_main   (pol_main),
    .pol_comp   (pol_comp),
    .off_run    (off_run),
    .off_idle   (off_idle),
    .oc_mode    (oc_mode),
    .oc_preload (oc_preload)
  );

  assign lock_level = lvl;
endmodule

// File: rtl/cfglock_checker.sv
module cfglock_checker #(
  parameter int NCH  = 2,
  parameter int DT_W = 8
) (
  input logic             clk,
  input logic             core_rst_n,
  input logic             wr_en,
  input logic [3:0]       wr_addr,
  input logic [15:0]      wr_data,
  input logic [NCH-1:0]   chan_out,
  input logic [1:0]       lock_level,
  input logic [DT_W-1:0]  dt_code,
  input logic [DT_W-1:0]  dt2_code,
  input logic             dt_preload,
  input logic [NCH-1:0]   pol_main,
  input logic [NCH-1:0]   pol_comp,
  input logic             off_run,
  input logic             off_idle,
  input logic [3*NCH-1:0] oc_mode,
  input logic [NCH-1:0]   oc_preload
);
  // R3: a committed nonzero level never moves until reset
  p_level_frozen_r3: assert property (@(posedge clk) disable iff (!core_rst_n)
    (lock_level != 2'd0) |=> $stable(lock_level));

  // R4: open level takes a dead-time write on the next edge
  p_open_write_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
    (lock_level == 2'd0 && wr_en && wr_addr == 4'h1) |=> (dt_code == $past(wr_data[DT_W-1:0])));

  // R5: dead-time code shielded at any nonzero level
  p_dt_shield_r5: assert property (@(posedge clk) disable iff (!core_rst_n)
    (lock_level != 2'd0 && wr_en && wr_addr == 4'h1) |=> $stable(dt_code));

  // R6: secondary dead-time and preload shielded at any nonzero level
  p_dt2_shield_r6: assert property (@(posedge clk) disable iff (!core_rst_n)
    (lock_level != 2'd0 && wr_en && wr_addr == 4'h4) |=> $stable({dt2_code, dt_preload}));

  // R7: off-state selects shielded from level 10 upward
  p_off_shield_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    (lock_level[1] && wr_en && wr_addr == 4'h6) |=> $stable({off_run, off_idle}));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    // R8: polarity of an output channel shielded from level 10 upward
    p_pol_shield_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
      (lock_level[1] && chan_out[c] && wr_en && wr_addr == 4'h5)
      |=> $stable({pol_main[c], pol_comp[c]}));

    // R9: compare controls of an output channel shielded at level 11
    p_mode_shield_r9: assert property (@(posedge clk) disable iff (!core_rst_n)
      (lock_level == 2'd3 && chan_out[c] && wr_en && wr_addr == 4'(8 + c))
      |=> $stable({oc_mode[3*c +: 3], oc_preload[c]}));

    // R9: compare controls of an input channel still written at level 11
    p_mode_open_r9: assert property (@(posedge clk) disable iff (!core_rst_n)
      (!chan_out[c] && wr_en && wr_addr == 4'(8 + c))
      |=> ({oc_preload[c], oc_mode[3*c +: 3]} == $past(wr_data[3:0])));
  end
endmodule

bind cfglock_top cfglock_checker #(.NCH(NCH), .DT_W(DT_W)) u_chk (
  .clk        (clk),
  .core_rst_n (core_rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .chan_out   (chan_out),
  .lock_level (lock_level),
  .dt_code    (dt_code),
  .dt2_code   (dt2_code),
  .dt_preload (dt_preload),
  .pol_main   (pol_main),
  .pol_comp   (pol_comp),
  .off_run    (off_run),
  .off_idle   (off_idle),
  .oc_mode    (oc_mode),
  .oc_preload (oc_preload)
);

// File: tb/cfglock_top_test.sv
`timescale 1ns/1ps
module cfglock_top_test;
  localparam int NCH = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  chan_out = '0;

  logic [1:0] lock_level;
  logic [7:0] dt_code, dt2_code;
  logic [3:0] brk_cfg;
  logic       auto_oe, dt_preload, off_run, off_idle;
  logic [1:0] idle_main, idle_comp, pol_main, pol_comp, oc_preload;
  logic [5:0] oc_mode;

  always #2 clk = ~clk;

  cfglock_top uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .chan_out(chan_out), .lock_level(lock_level), .dt_code(dt_code), .brk_cfg(brk_cfg),
    .auto_oe(auto_oe), .idle_main(idle_main), .idle_comp(idle_comp), .dt2_code(dt2_code),
    .dt_preload(dt_preload), .pol_main(pol_main), .pol_comp(pol_comp), .off_run(off_run),
    .off_idle(off_idle), .oc_mode(oc_mode), .oc_preload(oc_preload)
  );

  int checks = 0;
  int fails = 0;
  bit cmp_on = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_lvl, m_used, m_dt, m_brk, m_aoe, m_idm, m_idc, m_dt2, m_pre;
  int m_polm, m_polc, m_offr, m_offi;
  int m_mode[NCH];
  int m_mpre[NCH];

  function automatic void model_reset();
    m_lvl = 0; m_used = 0; m_dt = 0; m_brk = 0; m_aoe = 0; m_idm = 0; m_idc = 0;
    m_dt2 = 0; m_pre = 0; m_polm = 0; m_polc = 0; m_offr = 0; m_offi = 0;
    foreach (m_mode[c]) begin m_mode[c] = 0; m_mpre[c] = 0; end
  endfunction

  function automatic void model_write(int a, int d, int co);
    if (a == 0) begin
      if (m_used == 0) begin m_lvl = d & 3; m_used = 1; end
    end else if (a == 1) begin
      if (m_lvl == 0) m_dt = d & 255;
    end else if (a == 2) begin
      if (m_lvl == 0) begin m_brk = d & 15; m_aoe = (d >> 4) & 1; end
    end else if (a == 3) begin
      if (m_lvl == 0) begin m_idm = d & 3; m_idc = (d >> 2) & 3; end
    end else if (a == 4) begin
      if (m_lvl == 0) begin m_dt2 = d & 255; m_pre = (d >> 8) & 1; end
    end else if (a == 5) begin
      for (int c = 0; c < NCH; c++) begin
        if (!(m_lvl >= 2 && ((co >> c) & 1) == 1)) begin
          m_polm = (m_polm & ~(1 << c)) | (((d >> c) & 1) << c);
          m_polc = (m_polc & ~(1 << c)) | (((d >> (NCH + c)) & 1) << c);
        end
      end
    end else if (a == 6) begin
      if (m_lvl < 2) begin m_offr = d & 1; m_offi = (d >> 1) & 1; end
    end else if (a >= 8 && a < 8 + NCH) begin
      if (!(m_lvl == 3 && ((co >> (a - 8)) & 1) == 1)) begin
        m_mode[a - 8] = d & 7;
        m_mpre[a - 8] = (d >> 3) & 1;
      end
    end
  endfunction

  function automatic logic [41:0] model_vec();
    return {2'(m_lvl), 8'(m_dt), 4'(m_brk), 1'(m_aoe), 2'(m_idm), 2'(m_idc),
            8'(m_dt2), 1'(m_pre), 2'(m_polm), 2'(m_polc), 1'(m_offr), 1'(m_offi),
            3'(m_mode[1]), 3'(m_mode[0]), 1'(m_mpre[1]), 1'(m_mpre[0])};
  endfunction

  function automatic logic [41:0] dut_vec();
    return {lock_level, dt_code, brk_cfg, auto_oe, idle_main, idle_comp, dt2_code,
            dt_preload, pol_main, pol_comp, off_run, off_idle, oc_mode, oc_preload};
  endfunction

  task automatic chk(input string req, input logic [41:0] act, input logic [41:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    if (cmp_on) chk(cur_req, dut_vec(), model_vec());
  endtask

  task automatic step(input logic we, input logic [3:0] a, input logic [15:0] d,
                      input logic [1:0] co);
    @(negedge clk);
    compare();
    wr_en = we; wr_addr = a; wr_data = d; chan_out = co;
    if (we && rst_n) model_write(int'(a), int'(d), int'(co));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 4'h0, 16'h0, chan_out);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic [1:0] co);
    step(1'b1, a, d, co);
    idle(1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    compare();
    rst_n = 1'b0; wr_en = 1'b0;
    model_reset();
    idle(2);
    @(negedge clk);
    compare();
    rst_n = 1'b1;
    cmp_on = 1;
    idle(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    // R1: reset state
    cur_req = "R1";
    do_reset();
    chk("R1", {34'd0, lock_level, dt_code, oc_mode}, 42'd0);

    // R4: open level, all groups writable
    cur_req = "R4";
    wr(4'h1, 16'h00A5, 2'b11);
    chk("R4", 42'(dt_code), 42'hA5);
    wr(4'h2, 16'h001B, 2'b11);
    wr(4'h3, 16'h0009, 2'b11);
    wr(4'h4, 16'h01C3, 2'b11);
    chk("R4", 42'({dt_preload, dt2_code}), 42'h1C3);
    wr(4'h5, 16'h0006, 2'b11);
    wr(4'h6, 16'h0003, 2'b11);
    wr(4'h8, 16'h000D, 2'b11);
    wr(4'h9, 16'h0005, 2'b11);
    chk("R4", 42'({oc_preload, oc_mode}), 42'({2'b01, 3'd5, 3'd5}));

    // R12: unmapped addresses
    cur_req = "R12";
    wr(4'h7, 16'hFFFF, 2'b00);
    wr(4'hC, 16'hFFFF, 2'b00);
    chk("R12", 42'(dt_code), 42'hA5);

    // R2: commit level 01
    cur_req = "R2";
    wr(4'h0, 16'h0001, 2'b11);
    chk("R2", 42'(lock_level), 42'd1);
    // R3: second lock write ignored
    cur_req = "R3";
    wr(4'h0, 16'h0003, 2'b11);
    chk("R3", 42'(lock_level), 42'd1);
    // R5 / R6: tier one shielded
    cur_req = "R5";
    wr(4'h1, 16'h0011, 2'b11);
    chk("R5", 42'(dt_code), 42'hA5);
    wr(4'h2, 16'h0000, 2'b11);
    wr(4'h3, 16'h0000, 2'b11);
    cur_req = "R6";
    wr(4'h4, 16'h0000, 2'b11);
    chk("R6", 42'({dt_preload, dt2_code}), 42'h1C3);
    // R10: higher groups still open at level 01
    cur_req = "R10";
    wr(4'h5, 16'h0009, 2'b11);
    chk("R10", 42'({pol_comp, pol_main}), 42'h9);
    wr(4'h6, 16'h0000, 2'b11);
    wr(4'h8, 16'h0002, 2'b11);

    // R11: reset rearms; R2: first write of 00 uses the one-time write
    cur_req = "R11";
    do_reset();
    chk("R11", {lock_level, dt_code, pol_main, oc_mode}, 42'd0);
    cur_req = "R2";
    wr(4'h0, 16'h0000, 2'b00);
    cur_req = "R3";
    wr(4'h0, 16'h0002, 2'b00);
    chk("R3", 42'(lock_level), 42'd0);
    cur_req = "R4";
    wr(4'h1, 16'h0077, 2'b00);
    chk("R4", 42'(dt_code), 42'h77);

    // level 10: mixed-direction polarity write
    do_reset();
    cur_req = "R2";
    wr(4'h0, 16'h0002, 2'b01);
    cur_req = "R8";
    wr(4'h5, 16'h000F, 2'b01);
    chk("R8", 42'({pol_comp, pol_main}), 42'({2'b10, 2'b10}));
    cur_req = "R7";
    wr(4'h6, 16'h0003, 2'b01);
    chk("R7", 42'({off_run, off_idle}), 42'd0);
    cur_req = "R10";
    wr(4'h8, 16'h0006, 2'b11);
    chk("R10", 42'(oc_mode[2:0]), 42'd6);
    cur_req = "R5";
    wr(4'h1, 16'h00FF, 2'b00);
    chk("R5", 42'(dt_code), 42'd0);

    // level 11: compare controls per channel direction
    do_reset();
    cur_req = "R4";
    wr(4'h8, 16'h0003, 2'b00);
    wr(4'h9, 16'h0004, 2'b00);
    cur_req = "R2";
    wr(4'h0, 16'h0003, 2'b00);
    cur_req = "R9";
    wr(4'h8, 16'h000F, 2'b10);
    wr(4'h9, 16'h000F, 2'b10);
    chk("R9", 42'({oc_preload, oc_mode}), 42'({2'b01, 3'd4, 3'd7}));
    wr(4'h9, 16'h0007, 2'b00);
    chk("R9", 42'(oc_mode[5:3]), 42'd7);
    cur_req = "R8";
    wr(4'h5, 16'h000F, 2'b11);
    chk("R8", 42'({pol_comp, pol_main}), 42'd0);

    // randomized rounds over all levels and direction mixes
    for (int r = 0; r < 8; r++) begin
      cur_req = "R11";
      do_reset();
      cur_req = "random R4..R12";
      for (int k = 0; k < 80; k++) begin
        logic [3:0] a;
        a = (k == 30) ? 4'h0 : 4'($urandom_range(0, 15));
        if (a == 4'h0 && k != 30 && ($urandom_range(0, 3) != 0)) a = 4'h1;
        step(1'b1, a, 16'($urandom()), 2'($urandom_range(0, 3)));
      end
      idle(2);
    end

    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule